// File: doc/BRIEF.md
# USB FIFO Burst DMA Channel

This block is a single channel of a slave DMA engine that moves data between a USB function-controller FIFO and system memory. Software fills a small 32-bit register file with a memory address, a transaction count and a byte-enable mask for the final transaction, then sets the enable bit. The channel then runs the whole transfer as a series of fixed 32-byte transactions. For each one it issues a memory burst request that carries the address and byte enables, and then accepts eight beats on the FIFO ready/valid handshake.

The direction of the channel is fixed by a strap input. When data flows from memory to the FIFO, the source address register advances. When data flows from the FIFO to memory, the destination address register advances. Software can therefore work out the residue from the distance between the current address and the start address. A short packet from the FIFO can stall the channel and raise a flag. Software then turns that stall into a forced end of transfer.

A global register holds the master enable and the address-error flag. A software-reset register holds every piece of channel state in reset while it is set. The channel drives one level interrupt.

Top module: `usbdma_chan`

## Requirements
- R1: After reset, every register reads 0, and `mem_req`, `fifo_rdy` and `irq` are 0.
- R2: The channel registers sit at 0x20 + 0x20 × CH_INDEX, at these offsets: 0x00 source, 0x04 destination, 0x08 count, 0x14 control, 0x18 last mask. The count register keeps only its low 24 bits. The control bits are DE (0), TE (1), SP (2), IE (5), size (7:6), NULL (12), NULLE (16) and FTE (24, a write-only action). The global register at 0x60 holds DME (0) and AE (1). The reset register at 0x08 holds SWR (0).
- R3: A transaction starts only when all of these hold: DE=1, TE=0, SP=0, size=2'b10, DME=1, AE=0 and count≠0. Clearing DME or setting the wrong size prevents the next request.
- R4: `mem_req` stays high until `mem_gnt`. Then `fifo_rdy` accepts exactly 8 beats. After that the count drops by 1 and the active address register advances by 32: the destination register when `fifo_to_mem`=1, the source register otherwise. The other address register does not change. `mem_we` equals `fifo_to_mem`.
- R5: `mem_be` is all ones, except in the transaction where the count is 1. That transaction uses the last-mask register.
- R6: When the count reaches zero, TE is set and the channel issues no further request.
- R7: `irq` goes high one cycle after either of two conditions holds: IE=1 with TE or SP set, or NULLE=1 with NULL set.
- R8: Writing 0 to TE, SP or NULL clears that flag. Writing 1 leaves the flag unchanged.
- R9: If NULLE=1 and a beat arrives with `fifo_short`=1, NULL is set, `fifo_rdy` drops and the channel stalls. The count and the address stay where they were. If NULLE=0, `fifo_short` is ignored.
- R10: While the channel is stalled on a short packet, a write with FTE=1 sets TE and returns the channel to idle. At any other time FTE has no effect.
- R11: If a start is attempted while the active address has nonzero low 5 bits, AE and SP are set and no request is made. Writing 0 to bit 1 of the global register clears AE.
- R12: If DE is cleared during a transaction, that transaction completes and no further request follows.
- R13: While SWR=1, all channel registers and DME are held at 0, `mem_req` and `fifo_rdy` are low, and writes to the channel registers are ignored.
- R14: While DE=1 and TE=0, writes to the source, destination, count and mask registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_addr |
| fifo_to_mem | input | 1 | Direction strap: 1 = FIFO to memory |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Burst is a memory write |
| mem_addr | output | 32 | Burst address, 32-byte aligned |
| mem_be | output | 32 | Per-byte enables of the burst |
| mem_gnt | input | 1 | Burst request accepted |
| fifo_vld | input | 1 | FIFO beat valid |
| fifo_short | input | 1 | Beat ends a short or null packet |
| fifo_rdy | output | 1 | Channel accepts a FIFO beat |
| irq | output | 1 | Channel interrupt, level |

## Verification
The hardest state to reach is the short-packet stall. Getting there needs NULLE set, a granted burst and a partly accepted transaction, with the short marker placed on one chosen beat. The bench drives the grant and the beats by hand so that it can raise `fifo_short` on the fourth beat. It then confirms that the handshake stays closed while valid is still asserted. It tries FTE once during the pending request, where FTE must do nothing, and once during the stall, where FTE must end the transfer. Clearing DE while a request is pending is a second timed case: the channel must finish that burst and issue no request after it.

// File: rtl/usbdma_pkg.sv
package usbdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_BEAT = 2'd2,
    ST_HOLD = 2'd3
  } xfer_state_e;

  localparam int REG_AW = 8;

  // global register addresses
  localparam logic [REG_AW-1:0] ADR_SWR  = 8'h08;
  localparam logic [REG_AW-1:0] ADR_GCTL = 8'h60;

  // offsets inside a channel window
  localparam logic [4:0] OFS_SRC  = 5'h00;
  localparam logic [4:0] OFS_DST  = 5'h04;
  localparam logic [4:0] OFS_CNT  = 5'h08;
  localparam logic [4:0] OFS_CTL  = 5'h14;
  localparam logic [4:0] OFS_MASK = 5'h18;

  // control bit positions
  localparam int B_DE    = 0;
  localparam int B_TE    = 1;
  localparam int B_SP    = 2;
  localparam int B_IE    = 5;
  localparam int B_SZ_LO = 6;
  localparam int B_SZ_HI = 7;
  localparam int B_NULL  = 12;
  localparam int B_NULLE = 16;
  localparam int B_FTE   = 24;

  localparam logic [1:0] SZ_32B = 2'b10;

endpackage

// File: rtl/usbdma_gctl.sv
module usbdma_gctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_swr,
  input  logic wr_gctl,
  input  logic wbit0,
  input  logic wbit1,
  input  logic ae_set,
  output logic swr,
  output logic dme,
  output logic ae
);

  always_ff @(posedge clk) begin
    if (rst) begin
      swr <= 1'b0;
      dme <= 1'b0;
      ae  <= 1'b0;
    end else begin
      if (wr_swr) swr <= wbit0;
      if (swr) begin
        dme <= 1'b0;
        ae  <= 1'b0;
      end else begin
        if (wr_gctl) begin
          dme <= wbit0;
          if (!wbit1) ae <= 1'b0;
        end
        if (ae_set) ae <= 1'b1;
      end
    end
  end

  // R13: software reset forces the global enable low
  p_swr_clr_dme_r13: assert property (@(posedge clk) disable iff (rst)
    swr |=> !dme);

endmodule

// File: rtl/usbdma_engine.sv
module usbdma_engine
  import usbdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int BEATS      = 8,
  parameter int XFER_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_ok,
  input  logic                  sw_lock,
  input  logic                  fifo_to_mem,
  input  logic                  nulle,
  input  logic                  fte_go,
  input  logic                  wr_src,
  input  logic                  wr_dst,
  input  logic                  wr_cnt,
  input  logic                  wr_mask,
  input  logic [31:0]           wdata,
  input  logic                  mem_gnt,
  input  logic                  fifo_vld,
  input  logic                  fifo_short,
  output logic [ADDR_W-1:0]     src,
  output logic [ADDR_W-1:0]     dst,
  output logic [CNT_W-1:0]      cnt,
  output logic [XFER_BYTES-1:0] lmask,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [XFER_BYTES-1:0] mem_be,
  output logic                  fifo_rdy,
  output logic                  done_p,
  output logic                  null_p,
  output logic                  aerr_p,
  output logic                  fte_p
);

  localparam int BEAT_W  = $clog2(BEATS);
  localparam int ALIGN_W = $clog2(XFER_BYTES);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(XFER_BYTES);

  xfer_state_e       st;
  logic [BEAT_W-1:0] beat;
  logic              launch, aligned, hs, short_stop, last_hs;

  assign mem_addr   = fifo_to_mem ? dst : src;
  assign aligned    = (mem_addr[ALIGN_W-1:0] == '0);
  assign launch     = (st == ST_IDLE) && start_ok && (cnt != '0);
  assign hs         = (st == ST_BEAT) && fifo_vld;
  assign short_stop = hs && fifo_short && nulle;
  assign last_hs    = hs && !short_stop && (beat == LAST_BEAT);

  assign aerr_p   = launch && !aligned;
  assign null_p   = short_stop;
  assign done_p   = last_hs && (cnt == CNT_W'(1));
  assign fte_p    = (st == ST_HOLD) && fte_go;
  assign mem_req  = (st == ST_REQ);
  assign fifo_rdy = (st == ST_BEAT);
  assign mem_be   = (cnt == CNT_W'(1)) ? lmask : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      beat  <= '0;
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      lmask <= '0;
    end else begin
      if (!sw_lock) begin
        if (wr_src)  src   <= wdata[ADDR_W-1:0];
        if (wr_dst)  dst   <= wdata[ADDR_W-1:0];
        if (wr_cnt)  cnt   <= wdata[CNT_W-1:0];
        if (wr_mask) lmask <= wdata[XFER_BYTES-1:0];
      end
      case (st)
        ST_IDLE: if (launch && aligned) st <= ST_REQ;
        ST_REQ: if (mem_gnt) begin
          st   <= ST_BEAT;
          beat <= '0;
        end
        ST_BEAT: begin
          if (short_stop) begin
            st <= ST_HOLD;
          end else if (hs) begin
            if (beat == LAST_BEAT) begin
              st  <= ST_IDLE;
              cnt <= cnt - CNT_W'(1);
              if (fifo_to_mem) dst <= dst + STEP;
              else             src <= src + STEP;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
        end
        ST_HOLD: if (fte_go) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: a pending burst request is never withdrawn before its grant
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> mem_req);

  // R4: every burst address is transaction aligned
  p_addr_align_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_W-1:0] == '0));

  // R3: a request only opens after the start gate was satisfied
  p_launch_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(start_ok));

  // R9: a detected short packet closes the beat handshake
  p_short_stall_r9: assert property (@(posedge clk) disable iff (rst)
    null_p |=> !fifo_rdy);

endmodule

// File: rtl/usbdma_chan.sv
module usbdma_chan
  import usbdma_pkg::*;
#(
  parameter int CH_INDEX   = 0,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int BEATS      = 8,
  parameter int XFER_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [7:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  fifo_to_mem,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [XFER_BYTES-1:0] mem_be,
  input  logic                  mem_gnt,
  input  logic                  fifo_vld,
  input  logic                  fifo_short,
  output logic                  fifo_rdy,
  output logic                  irq
);

  localparam logic [REG_AW-1:0] CH_BASE = REG_AW'(32 + 32 * CH_INDEX);

  logic swr, dme, ae, chan_rst;
  logic is_glob, hit_ch;
  logic wr_src, wr_dst, wr_cnt, wr_ctl, wr_mask, wr_swr, wr_gctl;
  logic de_f, te_f, sp_f, ie_f, null_f, nulle_f;
  logic [1:0] sz_f;
  logic start_ok, sw_lock, fte_go;
  logic done_p, null_p, aerr_p, fte_p;
  logic [ADDR_W-1:0] src, dst;
  logic [CNT_W-1:0] cnt;
  logic [XFER_BYTES-1:0] lmask;
  logic [31:0] ctl_word;

  assign is_glob = (reg_addr == ADR_SWR) || (reg_addr == ADR_GCTL);
  assign hit_ch  = (reg_addr[7:5] == CH_BASE[7:5]) && !is_glob;
  assign wr_swr  = reg_we && (reg_addr == ADR_SWR);
  assign wr_gctl = reg_we && (reg_addr == ADR_GCTL);
  assign wr_src  = reg_we && hit_ch && (reg_addr[4:0] == OFS_SRC);
  assign wr_dst  = reg_we && hit_ch && (reg_addr[4:0] == OFS_DST);
  assign wr_cnt  = reg_we && hit_ch && (reg_addr[4:0] == OFS_CNT);
  assign wr_ctl  = reg_we && hit_ch && (reg_addr[4:0] == OFS_CTL);
  assign wr_mask = reg_we && hit_ch && (reg_addr[4:0] == OFS_MASK);

  assign chan_rst = rst || swr;
  assign start_ok = de_f && !te_f && !sp_f && dme && !ae && (sz_f == SZ_32B);
  assign sw_lock  = de_f && !te_f;
  assign fte_go   = wr_ctl && reg_wdata[B_FTE];
  assign mem_we   = fifo_to_mem;

  usbdma_gctl u_gctl (
    .clk     (clk),
    .rst     (rst),
    .wr_swr  (wr_swr),
    .wr_gctl (wr_gctl),
    .wbit0   (reg_wdata[0]),
    .wbit1   (reg_wdata[1]),
    .ae_set  (aerr_p),
    .swr     (swr),
    .dme     (dme),
    .ae      (ae)
  );

  usbdma_engine #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .BEATS      (BEATS),
    .XFER_BYTES (XFER_BYTES)
  ) u_engine (
    .clk         (clk),
    .rst         (chan_rst),
    .start_ok    (start_ok),
    .sw_lock     (sw_lock),
    .fifo_to_mem (fifo_to_mem),
    .nulle       (nulle_f),
    .fte_go      (fte_go),
    .wr_src      (wr_src),
    .wr_dst      (wr_dst),
    .wr_cnt      (wr_cnt),
    .wr_mask     (wr_mask),
    .wdata       (reg_wdata),
    .mem_gnt     (mem_gnt),
    .fifo_vld    (fifo_vld),
    .fifo_short  (fifo_short),
    .src         (src),
    .dst         (dst),
    .cnt         (cnt),
    .lmask       (lmask),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .fifo_rdy    (fifo_rdy),
    .done_p      (done_p),
    .null_p      (null_p),
    .aerr_p      (aerr_p),
    .fte_p       (fte_p)
  );

  // control and status flags; hardware set wins over a software clear
  always_ff @(posedge clk) begin
    if (chan_rst) begin
      de_f    <= 1'b0;
      te_f    <= 1'b0;
      sp_f    <= 1'b0;
      ie_f    <= 1'b0;
      sz_f    <= 2'b00;
      null_f  <= 1'b0;
      nulle_f <= 1'b0;
    end else begin
      if (wr_ctl) begin
        de_f    <= reg_wdata[B_DE];
        ie_f    <= reg_wdata[B_IE];
        sz_f    <= reg_wdata[B_SZ_HI:B_SZ_LO];
        nulle_f <= reg_wdata[B_NULLE];
        te_f    <= te_f   && reg_wdata[B_TE];
        sp_f    <= sp_f   && reg_wdata[B_SP];
        null_f  <= null_f && reg_wdata[B_NULL];
      end
      if (done_p || fte_p) te_f   <= 1'b1;
      if (aerr_p)          sp_f   <= 1'b1;
      if (null_p)          null_f <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (chan_rst) irq <= 1'b0;
    else          irq <= (ie_f && (te_f || sp_f)) || (nulle_f && null_f);
  end

  always_comb begin
    ctl_word                 = '0;
    ctl_word[B_DE]           = de_f;
    ctl_word[B_TE]           = te_f;
    ctl_word[B_SP]           = sp_f;
    ctl_word[B_IE]           = ie_f;
    ctl_word[B_SZ_HI:B_SZ_LO] = sz_f;
    ctl_word[B_NULL]         = null_f;
    ctl_word[B_NULLE]        = nulle_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr == ADR_SWR) begin
      reg_rdata <= {31'b0, swr};
    end else if (reg_addr == ADR_GCTL) begin
      reg_rdata <= {30'b0, ae, dme};
    end else if (hit_ch) begin
      case (reg_addr[4:0])
        OFS_SRC:  reg_rdata <= 32'(src);
        OFS_DST:  reg_rdata <= 32'(dst);
        OFS_CNT:  reg_rdata <= 32'(cnt);
        OFS_CTL:  reg_rdata <= ctl_word;
        OFS_MASK: reg_rdata <= 32'(lmask);
        default:  reg_rdata <= '0;
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

  // R6: a finished channel holds no request
  p_te_idle_r6: assert property (@(posedge clk) disable iff (chan_rst)
    te_f |-> !mem_req);

  // R13: software reset quiets both sides of the channel
  p_swr_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    swr |=> (!mem_req && !fifo_rdy));

  // R7: an enabled end or stop flag raises the interrupt next cycle
  p_irq_end_r7: assert property (@(posedge clk) disable iff (chan_rst)
    (ie_f && (te_f || sp_f)) |=> irq);

endmodule

// File: tb/usbdma_chan_tb.sv
`timescale 1ns/1ps
module usbdma_chan_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        fifo_to_mem;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_be;
  logic        fifo_vld, fifo_short, fifo_rdy, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [7:0] A_SRC  = 8'h20;
  localparam logic [7:0] A_DST  = 8'h24;
  localparam logic [7:0] A_CNT  = 8'h28;
  localparam logic [7:0] A_CTL  = 8'h34;
  localparam logic [7:0] A_MASK = 8'h38;
  localparam logic [7:0] A_SWR  = 8'h08;
  localparam logic [7:0] A_GCTL = 8'h60;

  always #4 clk = ~clk;

  usbdma_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_to_mem(fifo_to_mem),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_gnt(mem_gnt), .fifo_vld(fifo_vld), .fifo_short(fifo_short),
    .fifo_rdy(fifo_rdy), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
  endtask

  task automatic wait_req();
    for (int w = 0; w < 50 && !mem_req; w++) @(negedge clk);
  endtask

  task automatic xfer(logic [31:0] ea, logic [31:0] ebe, logic ewe,
                      int hold, string tag);
    int n = 0;
    wait_req();
    check({tag, " R4 req"}, {31'b0, mem_req}, 32'd1);
    check({tag, " R4 addr"}, mem_addr, ea);
    check({tag, " R5 be"}, mem_be, ebe);
    check({tag, " R4 we"}, {31'b0, mem_we}, {31'b0, ewe});
    for (int i = 0; i < hold; i++) @(negedge clk);
    if (hold > 0) check({tag, " R4 req held"}, {31'b0, mem_req}, 32'd1);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    fifo_vld = 1'b1;
    for (int w = 0; w < 40 && fifo_rdy; w++) begin
      n++;
      @(negedge clk);
    end
    fifo_vld = 1'b0;
    check({tag, " R4 beats"}, n, 32'd8);
  endtask

  task automatic t_reset();
    check("R1 mem_req", {31'b0, mem_req}, 0);
    check("R1 fifo_rdy", {31'b0, fifo_rdy}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd_chk(A_SRC, 0, "R1 src");
    rd_chk(A_DST, 0, "R1 dst");
    rd_chk(A_CNT, 0, "R1 cnt");
    rd_chk(A_CTL, 0, "R1 ctl");
    rd_chk(A_MASK, 0, "R1 mask");
    rd_chk(A_GCTL, 0, "R1 gctl");
    rd_chk(A_SWR, 0, "R1 swr");
  endtask

  task automatic t_regs();
    wr(A_CTL, 32'h0001_00A0);
    rd_chk(A_CTL, 32'h0001_00A0, "R2 ctl fields");
    wr(A_CNT, 32'hFFFF_FFFF);
    rd_chk(A_CNT, 32'h00FF_FFFF, "R2 cnt 24 bits");
    wr(A_CTL, 32'hFFFF_FFFF);
    rd_chk(A_CTL, 32'h0001_00E1, "R8 write 1 keeps flags clear");
    check("R3 no req without DME", {31'b0, mem_req}, 0);
    wr(A_CTL, 32'h0);
  endtask

  task automatic t_mem_to_fifo();
    fifo_to_mem = 1'b0;
    wr(A_GCTL, 32'h1);
    wr(A_SRC, 32'h0000_1000);
    wr(A_DST, 32'h0);
    wr(A_CNT, 32'd3);
    wr(A_MASK, 32'hFFFF_0000);
    wr(A_CTL, 32'h0000_00A1);
    xfer(32'h1000, 32'hFFFF_FFFF, 1'b0, 2, "m2f t0");
    xfer(32'h1020, 32'hFFFF_FFFF, 1'b0, 0, "m2f t1");
    xfer(32'h1040, 32'hFFFF_0000, 1'b0, 0, "m2f last");
    @(negedge clk);
    check("R6 no req after end", {31'b0, mem_req}, 0);
    check("R7 irq on TE", {31'b0, irq}, 1);
    rd_chk(A_CNT, 0, "R6 cnt zero");
    rd_chk(A_SRC, 32'h1060, "R4 src advanced");
    rd_chk(A_DST, 0, "R4 dst unchanged");
    rd_chk(A_CTL, 32'h0000_00A3, "R6 TE set");
    wr(A_CTL, 32'h0000_00A0);
    rd_chk(A_CTL, 32'h0000_00A0, "R8 TE cleared by 0");
    check("R7 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_fifo_to_mem();
    fifo_to_mem = 1'b1;
    wr(A_SRC, 32'h0000_0500);
    wr(A_DST, 32'h0000_2000);
    wr(A_CNT, 32'd1);
    wr(A_MASK, 32'h8000_0000);
    wr(A_CTL, 32'h0000_00A1);
    wait_req();
    wr(A_SRC, 32'hDEAD_0000);
    wr(A_CNT, 32'd5);
    xfer(32'h2000, 32'h8000_0000, 1'b1, 0, "f2m");
    rd_chk(A_SRC, 32'h0500, "R14 src write ignored");
    rd_chk(A_DST, 32'h2020, "R4 dst advanced");
    rd_chk(A_CNT, 0, "R14 cnt write ignored");
    wr(A_CTL, 32'h0000_00A0);
  endtask

  task automatic t_start_gate();
    bit seen = 1'b0;
    fifo_to_mem = 1'b0;
    wr(A_SRC, 32'h0000_0100);
    wr(A_CNT, 32'd2);
    wr(A_CTL, 32'h0000_0061);
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen |= mem_req; end
    check("R3 wrong size blocks", {31'b0, seen}, 0);
    wr(A_CTL, 32'h0000_0020);
    wr(A_GCTL, 32'h0);
    wr(A_CTL, 32'h0000_00A1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen |= mem_req; end
    check("R3 DME low blocks", {31'b0, seen}, 0);
    wr(A_CTL, 32'h0000_00A0);
    wr(A_GCTL, 32'h1);
    wr(A_CNT, 32'd0);
    wr(A_CTL, 32'h0000_00A1);
    for (int i = 0; i < 8; i++) begin @(negedge clk); seen |= mem_req; end
    check("R3 zero count blocks", {31'b0, seen}, 0);
    wr(A_CTL, 32'h0000_00A0);
    wr(A_CNT, 32'd1);
    wr(A_CTL, 32'h0000_00A1);
    xfer(32'h0100, 32'h8000_0000, 1'b0, 0, "R3 gate open");
    wr(A_CTL, 32'h0000_00A0);
  endtask

  task automatic t_addr_err();
    bit seen = 1'b0;
    fifo_to_mem = 1'b0;
    wr(A_SRC, 32'h0000_1004);
    wr(A_CNT, 32'd1);
    wr(A_CTL, 32'h0000_00A1);
    for (int i = 0; i < 6; i++) begin @(negedge clk); seen |= mem_req; end
    check("R11 unaligned no req", {31'b0, seen}, 0);
    rd_chk(A_GCTL, 32'h3, "R11 AE set");
    rd_chk(A_CTL, 32'h0000_00A5, "R11 SP set");
    check("R7 irq on SP", {31'b0, irq}, 1);
    wr(A_GCTL, 32'h1);
    rd_chk(A_GCTL, 32'h1, "R11 AE cleared");
    wr(A_CTL, 32'h0000_00A0);
    rd_chk(A_CTL, 32'h0000_00A0, "R8 SP cleared by 0");
  endtask

  task automatic t_abort();
    bit seen = 1'b0;
    fifo_to_mem = 1'b0;
    wr(A_SRC, 32'h0000_8000);
    wr(A_CNT, 32'd3);
    wr(A_CTL, 32'h0000_00A1);
    wait_req();
    wr(A_CTL, 32'h0000_00A0);
    xfer(32'h8000, 32'hFFFF_FFFF, 1'b0, 0, "R12 abort");
    for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= mem_req; end
    check("R12 no request after abort", {31'b0, seen}, 0);
    rd_chk(A_CNT, 32'd2, "R12 cnt");
    rd_chk(A_SRC, 32'h8020, "R12 src");
    rd_chk(A_CTL, 32'h0000_00A0, "R12 no TE");
  endtask

  task automatic t_short();
    fifo_to_mem = 1'b1;
    wr(A_DST, 32'h0000_3000);
    wr(A_CNT, 32'd4);
    wr(A_CTL, 32'h0001_00A1);
    wait_req();
    wr(A_CTL, 32'h0101_00A1);
    check("R10 FTE ignored while requesting", {31'b0, mem_req}, 1);
    rd_chk(A_CTL, 32'h0001_00A1, "R10 no TE from FTE");
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    fifo_vld = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R9 beat open", {31'b0, fifo_rdy}, 1);
      @(negedge clk);
    end
    fifo_short = 1'b1;
    check("R9 beat open at short", {31'b0, fifo_rdy}, 1);
    @(negedge clk);
    fifo_short = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check("R9 stalled", {31'b0, fifo_rdy}, 0);
      @(negedge clk);
    end
    fifo_vld = 1'b0;
    rd_chk(A_CTL, 32'h0001_10A1, "R9 NULL set");
    check("R7 irq on NULL", {31'b0, irq}, 1);
    rd_chk(A_DST, 32'h3000, "R9 dst held");
    rd_chk(A_CNT, 32'd4, "R9 cnt held");
    wr(A_CTL, 32'h0101_00A1);
    rd_chk(A_CTL, 32'h0001_00A3, "R10 FTE sets TE");
    check("R10 idle after FTE", {31'b0, mem_req | fifo_rdy}, 0);
    wr(A_CTL, 32'h0000_00A0);
    wr(A_DST, 32'h0000_4000);
    wr(A_CNT, 32'd1);
    wr(A_MASK, 32'hFFFF_FFFF);
    fifo_short = 1'b1;
    wr(A_CTL, 32'h0000_00A1);
    xfer(32'h4000, 32'hFFFF_FFFF, 1'b1, 0, "R9 short ignored");
    fifo_short = 1'b0;
    rd_chk(A_CTL, 32'h0000_00A3, "R9 normal end without NULLE");
    wr(A_CTL, 32'h0000_00A0);
  endtask

  task automatic t_swr();
    fifo_to_mem = 1'b0;
    wr(A_SRC, 32'h0000_9000);
    wr(A_CNT, 32'd2);
    wr(A_CTL, 32'h0000_00A1);
    wait_req();
    wr(A_SWR, 32'h1);
    @(negedge clk);
    check("R13 req dropped", {31'b0, mem_req | fifo_rdy}, 0);
    rd_chk(A_CTL, 0, "R13 ctl reset");
    rd_chk(A_SRC, 0, "R13 src reset");
    rd_chk(A_GCTL, 0, "R13 DME cleared");
    rd_chk(A_SWR, 32'h1, "R13 SWR reads 1");
    wr(A_SRC, 32'h0000_1234);
    rd_chk(A_SRC, 0, "R13 write ignored");
    wr(A_SWR, 32'h0);
    rd_chk(A_SWR, 0, "R13 SWR cleared");
    wr(A_GCTL, 32'h1);
    rd_chk(A_GCTL, 32'h1, "R13 DME resumes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    fifo_to_mem = 1'b0; mem_gnt = 1'b0; fifo_vld = 1'b0; fifo_short = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mem_to_fifo();
    t_fifo_to_mem();
    t_start_gate();
    t_addr_err();
    t_abort();
    t_short();
    t_swr();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule